// File: doc/BRIEF.md
# Flash program and erase controller

This block is a register-mapped controller that sits between a 32-bit register bus and an internal word array that stands in for on-chip flash. Software first unlocks the command registers with a key and sets write-enable. It then loads a byte address, latches it, and issues either a page erase or a one-word program at the latched address. Erase drives every word of the page to all ones. Programming can only clear bits, because the new word is the old contents AND the supplied data.

Each page has one protection bit. The bits are packed 32 pages per word, so page p sits in word p>>5 at bit p&31, and a 0 marks the page as protected. The sequencer checks this bit, together with the address range, whenever an address is latched or advanced. A six-bit status register reports busy, protection and range faults, data-ready, a program attempt made without a latched address, and an erase stopped by software.

The page size is 2^(code+10) bytes. Code 1 gives 2048 and code 2 gives 4096. The lock register offset has two variants selected by a parameter.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset the key register (offset 0x03C by default, 0x040 when LOCK_ALT=1) reads 1 (locked). The control register (0x008) reads 0 and the status register (0x01C) reads 0.
- R2: Writing 0x1B71 to the key register unlocks it, so it reads 0. Any other value locks it again. While locked, writes to the control register (bit 0 = write-enable) and to the command register (0x00C) have no effect. Writes to the address (0x010) and data (0x018) registers are always taken.
- R3: Command bit 0 copies the address register into the active address. In the same cycle it sets status bit 1 if the page's protection bit is 0, sets status bit 2 if the address is at or beyond NUM_PAGES × page bytes, and clears status bits 4 and 5. When bit 0 is set, the other bits of that command write are ignored.
- R4: Status bit 3 (data-ready) is 1 exactly when an address has been latched since reset and status bit 0 (busy) is 0.
- R5: Command bit 1, with write-enable set, an address latched and status bits 1 and 2 clear, erases the whole page holding the active address to 0xFFFFFFFF. Words are written in ascending order, one per cycle. Busy is held for the page's word count, and other pages are left unchanged.
- R6: Command bit 3, with the R5 conditions, stores (old word AND data register) at the active address after PROG_CYCLES busy cycles. The active address then advances by 4, and status bits 1 and 2 are re-evaluated for the new address.
- R7: An erase or program command issued while write-enable is 0 or status bit 1 or 2 is set changes neither the array nor busy.
- R8: A program command with write-enable set and no latched address (data-ready 0) sets status bit 4 and writes nothing.
- R9: Clearing write-enable during an erase stops it on the next cycle. Busy clears, status bit 5 sets, and words not yet reached keep their contents.
- R10: Command writes that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| mem_addr_i | input | MEM_AW | Word index for the array read port |
| mem_rdata_o | output | 32 | Array word at mem_addr_i |

## Verification
On every cycle, the assertions check that data-ready is never seen together with busy and that a protected write-enable stays unchanged. They also check that an erase only starts from a clean, enabled state and never leaves its page, that a completed program advances the address by exactly 4, and that an erase stops at once when write-enable drops. Only the bench scenarios can show the stored values: that erase yields all ones, that programming ANDs into old contents, that auto-advance crosses into a protected page, and that an aborted erase leaves the untouched tail intact. The key sequence, the refused commands and the timeout flag are also observed at the ports.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  localparam logic [7:0]  OFS_CTRL  = 8'h08;
  localparam logic [7:0]  OFS_CMD   = 8'h0C;
  localparam logic [7:0]  OFS_ADDR  = 8'h10;
  localparam logic [7:0]  OFS_DATA  = 8'h18;
  localparam logic [7:0]  OFS_STAT  = 8'h1C;
  localparam logic [7:0]  OFS_KEY_A = 8'h3C;
  localparam logic [7:0]  OFS_KEY_B = 8'h40;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_1B71;

  // status bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_PROT = 1;
  localparam int ST_RANGE = 2;
  localparam int ST_RDY  = 3;
  localparam int ST_TMO  = 4;
  localparam int ST_ABT  = 5;
  localparam int ST_W    = 6;

  // command bit positions
  localparam int CMD_LATCH = 0;
  localparam int CMD_ERASE = 1;
  localparam int CMD_PROG  = 3;

  function automatic int page_bytes(input int code);
    return 1 << (code + 10);
  endfunction
endpackage

// File: rtl/flash_pe_array.sv
module flash_pe_array #(
  parameter int WORDS = 2048,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [31:0]   rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [31:0]   rdata_b_o
);
  logic [31:0] cells [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = cells[raddr_a_i];
  assign rdata_b_o = cells[raddr_b_i];
endmodule

// File: rtl/flash_pe_regs.sv
module flash_pe_regs
  import flash_pe_pkg::*;
#(
  parameter bit LOCK_ALT = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [7:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  logic [ST_W-1:0] status_i,
  output logic            wren_o,
  output logic [31:0]     addrb_o,
  output logic [31:0]     wdat_o,
  output logic            cmd_vld_o,
  output logic [3:0]      cmd_o
);
  localparam logic [7:0] OFS_KEY = LOCK_ALT ? OFS_KEY_B : OFS_KEY_A;

  logic        locked_q;
  logic        wren_q;
  logic [31:0] addrb_q;
  logic [31:0] wdat_q;
  logic        wr;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b1;
      wren_q   <= 1'b0;
      addrb_q  <= '0;
      wdat_q   <= '0;
    end else if (wr) begin
      unique case (addr_i)
        OFS_KEY:  locked_q <= (wdata_i != UNLOCK_KEY);
        OFS_CTRL: if (!locked_q) wren_q <= wdata_i[0];
        OFS_ADDR: addrb_q <= wdata_i;
        OFS_DATA: wdat_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign cmd_vld_o = wr && (addr_i == OFS_CMD) && !locked_q;
  assign cmd_o     = wdata_i[3:0];
  assign wren_o    = wren_q;
  assign addrb_o   = addrb_q;
  assign wdat_o    = wdat_q;

  always_comb begin
    unique case (addr_i)
      OFS_KEY:  rdata_o = {31'd0, locked_q};
      OFS_CTRL: rdata_o = {31'd0, wren_q};
      OFS_ADDR: rdata_o = addrb_q;
      OFS_DATA: rdata_o = wdat_q;
      OFS_STAT: rdata_o = {{(32-ST_W){1'b0}}, status_i};
      default:  rdata_o = '0;
    endcase
  end

  assert_ctrl_guard_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_CTRL && locked_q) |=> $stable(wren_q));
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_pe_pkg::*;
#(
  parameter int PAGE_WORDS = 512,
  parameter int NUM_PAGES = 4,
  parameter int PROG_CYCLES = 4,
  parameter logic [NUM_PAGES-1:0] PAGE_OPEN = '1,
  localparam int MEM_WORDS = PAGE_WORDS * NUM_PAGES,
  localparam int MEM_AW = $clog2(MEM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              cmd_vld_i,
  input  logic [3:0]        cmd_i,
  input  logic [31:0]       addrb_i,
  input  logic [31:0]       wdat_i,
  output logic [MEM_AW-1:0] mem_raddr_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_waddr_o,
  output logic [31:0]       mem_wdata_o,
  output logic [ST_W-1:0]   status_o
);
  localparam int PWW = $clog2(PAGE_WORDS);
  localparam int PG_LSB = PWW + 2;
  localparam int NUM_LW = (NUM_PAGES + 31) / 32;
  localparam int PIW = $clog2(NUM_LW * 32);
  localparam longint MEM_BYTES = longint'(MEM_WORDS) * 4;
  localparam int CNT_MAX = (PAGE_WORDS > PROG_CYCLES) ? PAGE_WORDS : PROG_CYCLES;
  localparam int CW = $clog2(CNT_MAX);

  // protection words: page p at word p>>5, bit p&31 (flat index p)
  logic [NUM_LW*32-1:0] lock_flat;
  for (genvar w = 0; w < NUM_LW; w++) begin : g_lw
    for (genvar b = 0; b < 32; b++) begin : g_bit
      if (w * 32 + b < NUM_PAGES) begin : g_pg
        assign lock_flat[w*32+b] = PAGE_OPEN[w*32+b];
      end else begin : g_pad
        assign lock_flat[w*32+b] = 1'b1;
      end
    end
  end

  function automatic logic [1:0] addr_flags(input logic [31:0] a);
    logic ok;
    logic [PIW-1:0] pg;
    ok = (longint'(a) < MEM_BYTES);
    pg = a[PG_LSB +: PIW];
    // [1] protected, [0] out of range
    return {ok && !lock_flat[pg], !ok};
  endfunction

  logic              busy_q, erasing_q, have_q;
  logic              prot_q, range_q, tmo_q, abt_q;
  logic [31:0]       act_q;
  logic [31:0]       pdat_q;
  logic [CW-1:0]     cnt_q;
  logic [MEM_AW-1:0] ptr_q;
  logic [MEM_AW-1:0] act_word;
  logic [31:0]       act_next;
  logic [1:0]        fl_new, fl_next;
  logic              rdy;
  logic              prog_done;
  logic              clean;

  assign act_word  = act_q[MEM_AW+1:2];
  assign act_next  = act_q + 32'd4;
  assign fl_new    = addr_flags(addrb_i);
  assign fl_next   = addr_flags(act_next);
  assign rdy       = have_q && !busy_q;
  assign prog_done = busy_q && !erasing_q && (cnt_q == '0);
  assign clean     = wren_i && !prot_q && !range_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      erasing_q <= 1'b0;
      have_q    <= 1'b0;
      prot_q    <= 1'b0;
      range_q   <= 1'b0;
      tmo_q     <= 1'b0;
      abt_q     <= 1'b0;
      act_q     <= '0;
      pdat_q    <= '0;
      cnt_q     <= '0;
      ptr_q     <= '0;
    end else if (busy_q) begin
      if (erasing_q) begin
        if (!wren_i) begin
          busy_q    <= 1'b0;
          erasing_q <= 1'b0;
          abt_q     <= 1'b1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
          if (cnt_q == '0) begin
            busy_q    <= 1'b0;
            erasing_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end else if (cnt_q == '0) begin
        busy_q  <= 1'b0;
        act_q   <= act_next;
        prot_q  <= fl_next[1];
        range_q <= fl_next[0];
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (cmd_vld_i) begin
      if (cmd_i[CMD_LATCH]) begin
        act_q   <= addrb_i;
        have_q  <= 1'b1;
        prot_q  <= fl_new[1];
        range_q <= fl_new[0];
        tmo_q   <= 1'b0;
        abt_q   <= 1'b0;
      end else if (cmd_i[CMD_ERASE]) begin
        if (clean && have_q) begin
          busy_q    <= 1'b1;
          erasing_q <= 1'b1;
          ptr_q     <= {act_word[MEM_AW-1:PWW], {PWW{1'b0}}};
          cnt_q     <= CW'(PAGE_WORDS - 1);
        end
      end else if (cmd_i[CMD_PROG]) begin
        if (clean) begin
          if (!rdy) begin
            tmo_q <= 1'b1;
          end else begin
            busy_q    <= 1'b1;
            erasing_q <= 1'b0;
            cnt_q     <= CW'(PROG_CYCLES - 1);
            pdat_q    <= wdat_i;
          end
        end
      end
    end
  end

  assign mem_raddr_o = act_word;
  always_comb begin
    mem_we_o    = 1'b0;
    mem_waddr_o = act_word;
    mem_wdata_o = mem_rdata_i & pdat_q;
    if (busy_q && erasing_q) begin
      mem_we_o    = wren_i;
      mem_waddr_o = ptr_q;
      mem_wdata_o = '1;
    end else if (prog_done) begin
      mem_we_o = 1'b1;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[ST_BUSY]  = busy_q;
    status_o[ST_PROT]  = prot_q;
    status_o[ST_RANGE] = range_q;
    status_o[ST_RDY]   = rdy;
    status_o[ST_TMO]   = tmo_q;
    status_o[ST_ABT]   = abt_q;
  end

  assert_rdy_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_BUSY] |-> !status_o[ST_RDY]);

  assert_erase_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_q) && erasing_q) |-> ($past(wren_i) && !$past(prot_q) && !$past(range_q)));

  assert_erase_in_page_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && erasing_q) |-> (ptr_q[MEM_AW-1:PWW] == act_word[MEM_AW-1:PWW]));

  assert_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_done |=> (act_q == $past(act_q) + 32'd4));

  assert_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && erasing_q && !wren_i) |=> (!busy_q && abt_q));
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int PAGE_CODE = 1,
  parameter int NUM_PAGES = 4,
  parameter int PROG_CYCLES = 4,
  parameter bit LOCK_ALT = 1'b0,
  parameter logic [NUM_PAGES-1:0] PAGE_OPEN = ~(NUM_PAGES'(2)),
  localparam int PAGE_WORDS = page_bytes(PAGE_CODE) / 4,
  localparam int MEM_WORDS = PAGE_WORDS * NUM_PAGES,
  localparam int MEM_AW = $clog2(MEM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [MEM_AW-1:0] mem_addr_i,
  output logic [31:0]       mem_rdata_o
);
  logic [ST_W-1:0]   status;
  logic              wren, cmd_vld;
  logic [3:0]        cmd;
  logic [31:0]       addrb, wdat;
  logic [MEM_AW-1:0] seq_raddr, seq_waddr;
  logic [31:0]       seq_rdata, seq_wdata;
  logic              seq_we;

  flash_pe_regs #(.LOCK_ALT(LOCK_ALT)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (bus_req_i),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .status_i  (status),
    .wren_o    (wren),
    .addrb_o   (addrb),
    .wdat_o    (wdat),
    .cmd_vld_o (cmd_vld),
    .cmd_o     (cmd)
  );

  flash_pe_seq #(
    .PAGE_WORDS  (PAGE_WORDS),
    .NUM_PAGES   (NUM_PAGES),
    .PROG_CYCLES (PROG_CYCLES),
    .PAGE_OPEN   (PAGE_OPEN)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wren_i      (wren),
    .cmd_vld_i   (cmd_vld),
    .cmd_i       (cmd),
    .addrb_i     (addrb),
    .wdat_i      (wdat),
    .mem_raddr_o (seq_raddr),
    .mem_rdata_i (seq_rdata),
    .mem_we_o    (seq_we),
    .mem_waddr_o (seq_waddr),
    .mem_wdata_o (seq_wdata),
    .status_o    (status)
  );

  flash_pe_array #(.WORDS(MEM_WORDS)) u_array (
    .clk_i     (clk_i),
    .we_i      (seq_we),
    .waddr_i   (seq_waddr),
    .wdata_i   (seq_wdata),
    .raddr_a_i (seq_raddr),
    .rdata_a_o (seq_rdata),
    .raddr_b_i (mem_addr_i),
    .rdata_b_o (mem_rdata_o)
  );
endmodule

// File: tb/sim_flash_pe_ctrl.sv
module sim_flash_pe_ctrl;
  localparam int MEM_AW = 11;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_M = 2'd2, OP_I = 2'd3;
  localparam int NV = 44;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, mrdata;
  logic [MEM_AW-1:0] maddr = '0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_pe_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mem_addr_i(maddr), .mem_rdata_o(mrdata)
  );

  // {op, req, offset or word index, data or expected}
  localparam logic [53:0] TBL [NV] = '{
    {OP_W, 4'd2,  16'h003C, 32'h0000_1B71},
    {OP_R, 4'd2,  16'h003C, 32'h0000_0000},  // R2 unlocked
    {OP_W, 4'd2,  16'h0008, 32'h0000_0001},
    {OP_R, 4'd2,  16'h0008, 32'h0000_0001},
    {OP_W, 4'd3,  16'h0010, 32'h0000_0000},
    {OP_W, 4'd3,  16'h000C, 32'h0000_0001},
    {OP_R, 4'd4,  16'h001C, 32'h0000_0008},  // R4 ready after latch
    {OP_W, 4'd5,  16'h000C, 32'h0000_0002},
    {OP_R, 4'd5,  16'h001C, 32'h0000_0001},  // R5 busy
    {OP_I, 4'd5,  16'h0000, 32'h0000_0000},
    {OP_R, 4'd4,  16'h001C, 32'h0000_0008},
    {OP_M, 4'd5,  16'h0000, 32'hFFFF_FFFF},
    {OP_M, 4'd5,  16'h01FF, 32'hFFFF_FFFF},
    {OP_W, 4'd6,  16'h0018, 32'hF0F0_FF00},
    {OP_W, 4'd6,  16'h000C, 32'h0000_0008},
    {OP_I, 4'd6,  16'h0000, 32'h0000_0000},
    {OP_M, 4'd6,  16'h0000, 32'hF0F0_FF00},
    {OP_W, 4'd6,  16'h0018, 32'h0FF0_1234},
    {OP_W, 4'd6,  16'h000C, 32'h0000_0008},
    {OP_I, 4'd6,  16'h0000, 32'h0000_0000},
    {OP_M, 4'd6,  16'h0001, 32'h0FF0_1234},  // R6 auto advance
    {OP_W, 4'd6,  16'h0010, 32'h0000_0000},
    {OP_W, 4'd6,  16'h000C, 32'h0000_0001},
    {OP_W, 4'd6,  16'h0018, 32'hFF00_FFFF},
    {OP_W, 4'd6,  16'h000C, 32'h0000_0008},
    {OP_I, 4'd6,  16'h0000, 32'h0000_0000},
    {OP_M, 4'd6,  16'h0000, 32'hF000_FF00},  // R6 AND into old
    {OP_W, 4'd3,  16'h0010, 32'h0000_0800},
    {OP_W, 4'd3,  16'h000C, 32'h0000_0001},
    {OP_R, 4'd3,  16'h001C, 32'h0000_000A},  // R3 protected page
    {OP_W, 4'd7,  16'h000C, 32'h0000_0002},
    {OP_R, 4'd7,  16'h001C, 32'h0000_000A},  // R7 erase refused
    {OP_W, 4'd3,  16'h0010, 32'h0000_2000},
    {OP_W, 4'd3,  16'h000C, 32'h0000_0001},
    {OP_R, 4'd3,  16'h001C, 32'h0000_000C},  // R3 out of range
    {OP_W, 4'd7,  16'h000C, 32'h0000_0008},
    {OP_R, 4'd7,  16'h001C, 32'h0000_000C},  // R7 program refused
    {OP_W, 4'd6,  16'h0010, 32'h0000_07FC},
    {OP_W, 4'd6,  16'h000C, 32'h0000_0001},
    {OP_W, 4'd6,  16'h0018, 32'hAAAA_5555},
    {OP_W, 4'd6,  16'h000C, 32'h0000_0008},
    {OP_I, 4'd6,  16'h0000, 32'h0000_0000},
    {OP_M, 4'd6,  16'h01FF, 32'hAAAA_5555},
    {OP_R, 4'd6,  16'h001C, 32'h0000_000A}   // R6 flags re-evaluated
  };

  task automatic check(input int r, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input int r, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(r, "reg", rdata, exp);
  endtask

  task automatic mem_chk(input int r, input logic [MEM_AW-1:0] w, input logic [31:0] exp);
    maddr = w;
    #1;
    check(r, "mem", mrdata, exp);
  endtask

  task automatic wait_idle(input int r);
    int n;
    n = 0;
    addr = 8'h1C;
    #1;
    while (rdata[0] && n < 4000) begin
      @(negedge clk);
      #1;
      n++;
    end
    if (rdata[0]) check(r, "idle timeout", rdata, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    rd_chk(1, 8'h3C, 32'h1);
    rd_chk(1, 8'h08, 32'h0);
    rd_chk(1, 8'h1C, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      int          rq;
      logic [15:0] a;
      logic [31:0] d;
      op = TBL[i][53:52];
      rq = int'(TBL[i][51:48]);
      a  = TBL[i][47:32];
      d  = TBL[i][31:0];
      case (op)
        OP_W: wr(a[7:0], d);
        OP_R: rd_chk(rq, a[7:0], d);
        OP_M: mem_chk(rq, a[MEM_AW-1:0], d);
        default: wait_idle(rq);
      endcase
    end

    // R2 locked: control and command writes dropped, address write taken
    wr(8'h3C, 32'h0);
    rd_chk(2, 8'h3C, 32'h1);
    wr(8'h08, 32'h0);
    rd_chk(2, 8'h08, 32'h1);
    wr(8'h10, 32'h0000_2000);
    wr(8'h0C, 32'h1);
    rd_chk(2, 8'h1C, 32'h0000_000A);
    rd_chk(2, 8'h10, 32'h0000_2000);
    wr(8'h3C, 32'h1B71);

    // R3 latch with erase bit in same write: latch only
    wr(8'h10, 32'h0000_1000);
    wr(8'h0C, 32'h3);
    rd_chk(3, 8'h1C, 32'h0000_0008);

    // R10 command during erase ignored
    wr(8'h0C, 32'h2);
    wr(8'h10, 32'h0000_0800);
    wr(8'h0C, 32'h1);
    wait_idle(10);
    rd_chk(10, 8'h1C, 32'h0000_0008);
    mem_chk(5, 11'h400, 32'hFFFF_FFFF);
    mem_chk(5, 11'h5FF, 32'hFFFF_FFFF);

    // prepare page 2 for abort
    wr(8'h10, 32'h0000_1000);
    wr(8'h0C, 32'h1);
    wr(8'h18, 32'h0);
    wr(8'h0C, 32'h8);
    wait_idle(6);
    mem_chk(6, 11'h400, 32'h0);
    wr(8'h10, 32'h0000_17FC);
    wr(8'h0C, 32'h1);
    wr(8'h18, 32'h1234_5678);
    wr(8'h0C, 32'h8);
    wait_idle(6);
    mem_chk(6, 11'h5FF, 32'h1234_5678);

    // R9 abort erase by clearing write-enable
    wr(8'h10, 32'h0000_1000);
    wr(8'h0C, 32'h1);
    wr(8'h0C, 32'h2);
    wr(8'h08, 32'h0);
    @(negedge clk);
    rd_chk(9, 8'h1C, 32'h0000_0028);
    mem_chk(9, 11'h400, 32'hFFFF_FFFF);
    mem_chk(9, 11'h5FF, 32'h1234_5678);

    // R7 write-enable low: erase and program refused
    wr(8'h0C, 32'h2);
    rd_chk(7, 8'h1C, 32'h0000_0028);
    wr(8'h18, 32'h0);
    wr(8'h0C, 32'h8);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    mem_chk(7, 11'h400, 32'hFFFF_FFFF);
    mem_chk(7, 11'h5FF, 32'h1234_5678);
    // R3 latch clears abort flag
    wr(8'h0C, 32'h1);
    rd_chk(3, 8'h1C, 32'h0000_0008);

    // R8 program without latched address
    do_reset();
    rd_chk(1, 8'h1C, 32'h0);
    wr(8'h3C, 32'h1B71);
    wr(8'h08, 32'h1);
    wr(8'h18, 32'h0);
    wr(8'h0C, 32'h8);
    rd_chk(8, 8'h1C, 32'h0000_0010);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    mem_chk(8, 11'h000, 32'hF000_FF00);
    wr(8'h10, 32'h0);
    wr(8'h0C, 32'h1);
    rd_chk(8, 8'h1C, 32'h0000_0008);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule